// File: doc/BRIEF.md
# Power Control, ACPI Mode Command and Platform Reset Register Block

This block sits on a simple I/O-port slave bus. It holds three registers. The first is a 16-bit power-state control register, which holds the requested sleep type and a read-only ACPI-mode flag. The second is a write-only 8-bit command register, which switches ACPI mode on or off. The third is an 8-bit platform reset register at port 0xCF9.

The block does not sequence power or distribute reset. It only turns bus writes into requests:
- a single-cycle soft-off pulse, raised when software writes the sleep-enable bit together with sleep type 5;
- a single-cycle system-reset pulse, raised when a reset-register write has bit 2 set;
- two level outputs, ACPI-mode enabled and power-button path armed, which the event logic downstream uses to gate the power button.

Bus writes take effect on the clock edge where they are sampled. Request pulses and state changes appear in the cycle that follows. Reads are combinational and return the selected register while `bus_rd` is high.

Top module: `pwrctl_top`

## Requirements
- R1: After reset, all stored registers read zero. `acpi_mode`, `pwrbtn_armed`, `softoff_req` and `sysreset_req` are all low.
- R2: A word write to the control register stores write bits 12:2. Bits 15, 14, 13 and 1 always read back as zero, so the sleep-enable bit (bit 13) is never stored.
- R3: A control-register write never changes control bit 0 (the ACPI-mode flag).
- R4: A control-register write with bit 13 set and bits 12:10 equal to 5 raises `softoff_req` in the following cycle. With any other sleep type, or with bit 13 clear, `softoff_req` stays low.
- R5: Access widths are fixed. The control register takes only word accesses (`bus_size`=1). The command and reset registers take only byte accesses (`bus_size`=0). An access of any other width leaves state unchanged, and a read of that width returns zero.
- R6: A byte write of `ENABLE_CODE` (default 0xA0) to the command register sets `acpi_mode`, control bit 0 and `pwrbtn_armed`. A byte write of `DISABLE_CODE` (default 0xA1) clears all three. Any other value changes nothing. A read of the command register returns zero.
- R7: The reset register reads back the last byte written to it. A write with bit 2 set raises `sysreset_req` in the following cycle. Bit 1 is stored but has no effect on the request.
- R8: Each request output is high for exactly one cycle per triggering write. Back-to-back triggering writes give one pulse per write, with no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| bus_addr | input | 16 | I/O port address |
| bus_size | input | 2 | Access width: 0 byte, 1 word, 2 dword |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no register is selected |
| bus_hit | output | 1 | An access with valid address and width targets this block |
| acpi_mode | output | 1 | ACPI mode enabled (control bit 0) |
| pwrbtn_armed | output | 1 | Power-button event path armed |
| softoff_req | output | 1 | One-cycle soft power-off request |
| sysreset_req | output | 1 | One-cycle system reset request |

## Verification
Assertions check the following on every cycle:
- the armed output always matches the ACPI-mode flag;
- the flag holds steady unless a mode command arrives;
- an unrecognised command leaves the armed state alone;
- every request pulse traces back to a qualifying write one cycle earlier;
- register writes land exactly as masked;
- at most one register is selected at a time.

Only the bench scenarios can show the remaining behaviour:
- the absence of a pulse for non-5 sleep types;
- that wrong-width accesses are ignored;
- the read-back values after sequences of mode commands mixed with control writes;
- that back-to-back requests produce one pulse per write.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic ctl;
    logic cmd;
    logic rst;
  } reg_sel_t;

  localparam int unsigned CTL_W        = 16;
  localparam int unsigned BYTE_W       = 8;
  localparam int unsigned SLP_TYP_LO   = 10;
  localparam int unsigned SLP_TYP_HI   = 12;
  localparam int unsigned SLP_GO_BIT   = 13;
  localparam int unsigned RST_GO_BIT   = 2;
  localparam logic [2:0]  SOFTOFF_TYPE = 3'd5;
  localparam logic [CTL_W-1:0] CTL_STORE_MASK = 16'h1FFC;
endpackage

// File: rtl/pwrctl_decode.sv
module pwrctl_decode
  import pwrctl_pkg::*;
#(
  parameter int unsigned   AW       = 16,
  parameter logic [AW-1:0] CTL_ADDR = 16'h0404,
  parameter logic [AW-1:0] CMD_ADDR = 16'h00B2,
  parameter logic [AW-1:0] RST_ADDR = 16'h0CF9
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output reg_sel_t      sel,
  output logic          hit
);
  always_comb begin
    sel     = '0;
    sel.ctl = (addr == CTL_ADDR) && (size == SZ_WORD);
    sel.cmd = (addr == CMD_ADDR) && (size == SZ_BYTE);
    sel.rst = (addr == RST_ADDR) && (size == SZ_BYTE);
    hit     = |sel;
  end

  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0({sel.ctl, sel.cmd, sel.rst})); // R5
  end
endmodule

// File: rtl/pwrctl_cmd.sv
module pwrctl_cmd
  import pwrctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ENABLE_CODE  = 8'hA0,
  parameter logic [BYTE_W-1:0] DISABLE_CODE = 8'hA1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic              mode_set,
  output logic              mode_clr,
  output logic              armed
);
  logic armed_d;
  logic armed_ce;

  always_comb begin
    mode_set = wr_en && (wdata == ENABLE_CODE);
    mode_clr = wr_en && (wdata == DISABLE_CODE);
    armed_ce = mode_set || mode_clr;
    armed_d  = mode_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (armed_ce) begin
      armed <= armed_d;
    end
  end

  AST_CMD_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != ENABLE_CODE && wdata != DISABLE_CODE) |=> $stable(armed)); // R6
endmodule

// File: rtl/pwrctl_ctl_reg.sv
module pwrctl_ctl_reg
  import pwrctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             mode_set,
  input  logic             mode_clr,
  output logic [CTL_W-1:0] ctl_q,
  output logic             softoff_req
);
  logic [CTL_W-1:0] ctl_d;
  logic             ctl_ce;
  logic             softoff_d;

  always_comb begin
    ctl_ce = wr_en || mode_set || mode_clr;
    ctl_d  = ctl_q;
    if (wr_en) begin
      ctl_d = (wdata & CTL_STORE_MASK) | (ctl_q & ~CTL_STORE_MASK & 16'h0001);
    end
    if (mode_set) begin
      ctl_d[0] = 1'b1;
    end else if (mode_clr) begin
      ctl_d[0] = 1'b0;
    end
    softoff_d = wr_en && wdata[SLP_GO_BIT] &&
                (wdata[SLP_TYP_HI:SLP_TYP_LO] == SOFTOFF_TYPE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      softoff_req <= 1'b0;
    end else begin
      softoff_req <= softoff_d;
      if (ctl_ce) begin
        ctl_q <= ctl_d;
      end
    end
  end

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_set && !mode_clr) |=> $stable(ctl_q[0])); // R3
  AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl_q[SLP_TYP_HI:2] == $past(wdata[SLP_TYP_HI:2]))); // R2
  AST_SOFTOFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    softoff_req |-> $past(wr_en && wdata[SLP_GO_BIT] &&
                          wdata[SLP_TYP_HI:SLP_TYP_LO] == SOFTOFF_TYPE)); // R4
endmodule

// File: rtl/pwrctl_rst_reg.sv
module pwrctl_rst_reg
  import pwrctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rst_q,
  output logic              sysreset_req
);
  logic [BYTE_W-1:0] rst_d;
  logic              req_d;

  always_comb begin
    rst_d = wr_en ? wdata : rst_q;
    req_d = wr_en && wdata[RST_GO_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q        <= '0;
      sysreset_req <= 1'b0;
    end else begin
      sysreset_req <= req_d;
      if (wr_en) begin
        rst_q <= rst_d;
      end
    end
  end

  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sysreset_req |-> $past(wr_en && wdata[RST_GO_BIT])); // R7
  AST_RST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rst_q == $past(wdata))); // R7
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
  import pwrctl_pkg::*;
#(
  parameter int unsigned       AW           = 16,
  parameter logic [AW-1:0]     CTL_ADDR     = 16'h0404,
  parameter logic [AW-1:0]     CMD_ADDR     = 16'h00B2,
  parameter logic [AW-1:0]     RST_ADDR     = 16'h0CF9,
  parameter logic [BYTE_W-1:0] ENABLE_CODE  = 8'hA0,
  parameter logic [BYTE_W-1:0] DISABLE_CODE = 8'hA1,
  parameter int unsigned       SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          bus_hit,
  output logic          acpi_mode,
  output logic          pwrbtn_armed,
  output logic          softoff_req,
  output logic          sysreset_req
);
  localparam int unsigned PAD_W = CTL_W - BYTE_W;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_core_n;
  reg_sel_t               sel;
  logic                   mode_set;
  logic                   mode_clr;
  logic [CTL_W-1:0]       ctl_q;
  logic [BYTE_W-1:0]      rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[SYNC_STAGES-1];

  pwrctl_decode #(
    .AW(AW), .CTL_ADDR(CTL_ADDR), .CMD_ADDR(CMD_ADDR), .RST_ADDR(RST_ADDR)
  ) u_decode (
    .addr(bus_addr), .size(bus_size), .sel(sel), .hit(bus_hit)
  );

  pwrctl_cmd #(
    .ENABLE_CODE(ENABLE_CODE), .DISABLE_CODE(DISABLE_CODE)
  ) u_cmd (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_wr && sel.cmd),
    .wdata(bus_wdata[BYTE_W-1:0]), .mode_set(mode_set),
    .mode_clr(mode_clr), .armed(pwrbtn_armed)
  );

  pwrctl_ctl_reg u_ctl (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_wr && sel.ctl),
    .wdata(bus_wdata), .mode_set(mode_set), .mode_clr(mode_clr),
    .ctl_q(ctl_q), .softoff_req(softoff_req)
  );

  pwrctl_rst_reg u_rst (
    .clk(clk), .rst_n(rst_core_n), .wr_en(bus_wr && sel.rst),
    .wdata(bus_wdata[BYTE_W-1:0]), .rst_q(rst_q),
    .sysreset_req(sysreset_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel.ctl) begin
        bus_rdata = ctl_q;
      end else if (sel.rst) begin
        bus_rdata = {{PAD_W{1'b0}}, rst_q};
      end
    end
  end

  assign acpi_mode = ctl_q[0];

  AST_ARM_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rst_core_n)
    pwrbtn_armed == acpi_mode); // R6
endmodule

// File: tb/test_pwrctl_top.sv
module test_pwrctl_top;
  localparam logic [15:0] A_CTL = 16'h0404;
  localparam logic [15:0] A_CMD = 16'h00B2;
  localparam logic [15:0] A_RST = 16'h0CF9;

  typedef enum int {K_RDATA, K_SOFTOFF, K_SYSRST, K_MODE, K_ARMED} kind_e;
  typedef struct {
    kind_e       kind;
    logic [15:0] exp;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_hit;
  logic        acpi_mode, pwrbtn_armed, softoff_req, sysreset_req;

  item_t exp_q[$];
  event  chk_ev;
  int    n_run = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;

  always #4 clk = ~clk;

  pwrctl_top i_pwrctl_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_hit(bus_hit), .acpi_mode(acpi_mode),
    .pwrbtn_armed(pwrbtn_armed), .softoff_req(softoff_req),
    .sysreset_req(sysreset_req)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] got;
        it = exp_q.pop_front();
        case (it.kind)
          K_RDATA:   got = bus_rdata;
          K_SOFTOFF: got = {15'd0, softoff_req};
          K_SYSRST:  got = {15'd0, sysreset_req};
          K_MODE:    got = {15'd0, acpi_mode};
          default:   got = {15'd0, pwrbtn_armed};
        endcase
        n_run++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic push(kind_e k, logic [15:0] e, string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    exp_q.push_back(it);
  endtask

  task automatic flush();
    #1;
    ->chk_ev;
    #1;
  endtask

  // write held for one edge; returns at the negedge after capture
  task automatic wr(logic [15:0] a, logic [1:0] s, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(logic [15:0] a, logic [1:0] s, logic [15:0] e, string r);
    @(negedge clk);
    bus_addr = a; bus_size = s; bus_rd = 1'b1;
    push(K_RDATA, e, r);
    flush();
    bus_rd = 1'b0;
  endtask

  task automatic pulses(logic [15:0] so, logic [15:0] sr, string r);
    push(K_SOFTOFF, so, r);
    push(K_SYSRST, sr, r);
    flush();
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    push(K_MODE, 0, "R1"); push(K_ARMED, 0, "R1");
    pulses(0, 0, "R1");
    rd_expect(A_CTL, 2'd1, 16'h0000, "R1");
    rd_expect(A_RST, 2'd0, 16'h0000, "R1");

    // R2 masking; bit13 with type 7 gives no pulse (R4)
    wr(A_CTL, 2'd1, 16'hFFFF);
    pulses(0, 0, "R4");
    rd_expect(A_CTL, 2'd1, 16'h1FFC, "R2");

    // R6 unknown command ignored, then enable
    wr(A_CMD, 2'd0, 16'h0055);
    push(K_MODE, 0, "R6"); push(K_ARMED, 0, "R6"); flush();
    wr(A_CMD, 2'd0, 16'h00A0);
    push(K_MODE, 1, "R6"); push(K_ARMED, 1, "R6"); flush();
    rd_expect(A_CTL, 2'd1, 16'h1FFD, "R6");
    rd_expect(A_CMD, 2'd0, 16'h0000, "R6");

    // R3 control write cannot clear the mode flag
    wr(A_CTL, 2'd1, 16'h0000);
    rd_expect(A_CTL, 2'd1, 16'h0001, "R3");
    push(K_MODE, 1, "R3"); flush();
    wr(A_CMD, 2'd0, 16'h00A1);
    push(K_MODE, 0, "R6"); push(K_ARMED, 0, "R6"); flush();
    wr(A_CTL, 2'd1, 16'hFFFF);
    rd_expect(A_CTL, 2'd1, 16'h1FFC, "R3");

    // R4 soft-off with type 5 and bit13
    wr(A_CTL, 2'd1, 16'h3400);
    pulses(1, 0, "R4");
    @(negedge clk);
    pulses(0, 0, "R8");
    rd_expect(A_CTL, 2'd1, 16'h1400, "R2");
    wr(A_CTL, 2'd1, 16'h1400);
    pulses(0, 0, "R4");
    wr(A_CTL, 2'd1, 16'h2C00);
    pulses(0, 0, "R4");

    // R8 back-to-back soft-off writes
    @(negedge clk);
    bus_addr = A_CTL; bus_size = 2'd1; bus_wdata = 16'h3400; bus_wr = 1'b1;
    @(negedge clk);
    pulses(1, 0, "R8");
    @(negedge clk);
    bus_wr = 1'b0;
    pulses(1, 0, "R8");
    @(negedge clk);
    pulses(0, 0, "R8");

    // R5 width checks
    wr(A_CTL, 2'd0, 16'h00FF);
    rd_expect(A_CTL, 2'd1, 16'h1400, "R5");
    rd_expect(A_CTL, 2'd0, 16'h0000, "R5");
    wr(A_CMD, 2'd1, 16'h00A0);
    push(K_MODE, 0, "R5"); push(K_ARMED, 0, "R5"); flush();
    wr(A_RST, 2'd1, 16'h0004);
    pulses(0, 0, "R5");
    rd_expect(A_RST, 2'd0, 16'h0000, "R5");

    // R7 reset register
    wr(A_RST, 2'd0, 16'h0002);
    pulses(0, 0, "R7");
    rd_expect(A_RST, 2'd0, 16'h0002, "R7");
    rd_expect(A_RST, 2'd2, 16'h0000, "R5");
    wr(A_RST, 2'd0, 16'h0006);
    pulses(0, 1, "R7");
    @(negedge clk);
    pulses(0, 0, "R8");
    rd_expect(A_RST, 2'd0, 16'h0006, "R7");
    wr(A_RST, 2'd0, 16'h0004);
    pulses(0, 1, "R7");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule